// File: doc/BRIEF.md
# UART Host Register Front End

This block sits between a byte-wide host bus and the serial engine of a small UART. A host access is qualified by an active-low chip select together with an active-low read or write strobe. The block holds the line configuration in two mode registers and turns command writes into enable levels for the receiver and transmitter, plus single-clock command strobes. It also steers host accesses that share an address onto separate read-side and write-side registers.

The two mode registers share one address. A small pointer decides which one an access reaches. Both reads and writes advance it, and only a pointer-reset command brings it back. A single command write carries a 4-bit command code in its upper half and four independent enable/disable bits in its lower half. Both halves act in the same write. The shifters, FIFOs and baud logic live elsewhere: their state comes in as plain status bytes, and the block drives out the decoded configuration fields, the command strobes, and load and pop strobes for the holding registers.

Top module: `uart_host_regs`

## Requirements
- R1: After synchronous reset, the mode pointer selects mode register 1, both mode registers hold zero, the receiver and transmitter are disabled, the clock-select, transmit-holding and interrupt-mask bytes are zero, and no strobe is active.
- R2: A write happens only while chip select and write strobe are both low. It takes effect on the clock edge at which the strobe is first seen released. It uses the address and data present on the last clock of the strobe. A strobe with chip select high has no effect.
- R3: Address 0 reaches mode register 1 on the first access after reset or after a pointer reset, and mode register 2 on every later access. Reads and writes advance the same pointer, and the pointer moves when the read or write completes.
- R4: Mode register 1 decodes as follows: bits 1:0 give the character length (0..3 for 5..8 bits); bit 2 selects odd parity; bits 4:3 give the parity mode (0 with, 1 forced, 2 none, 3 special); bit 5 selects block error mode; bit 6 moves the receive interrupt to FIFO full; bit 7 enables receiver RTS control.
- R5: Mode register 2 decodes as follows: bits 7:6 give the channel mode (0 normal, 1 echo, 2 local loop, 3 remote loop); bit 5 enables transmitter RTS control; bit 4 lets CTS gate the transmitter; bits 3:0 give the stop-length code.
- R6: A write to address 2 with code c = bits 7:4 in 1..12 raises cmd_pulse[c-1] for exactly one clock, on the clock after the write takes effect. Codes 0, 13, 14 and 15 raise no strobe. Code 1 also returns the mode pointer to mode register 1.
- R7: In the same write to address 2, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. When both bits of one direction are set, disable wins. When neither is set, that enable holds its value.
- R8: Address 1 reads the status byte and writes clock select. Address 3 reads the receive-holding byte and writes transmit holding; the write pulses tx_load for one clock and the completed read pulses rx_pop for one clock. Address 5 reads the interrupt status byte and writes the interrupt mask. Address 0 reads the selected mode register.
- R9: Writes to addresses 4, 6 and 7 change no output and no register. Reads of addresses 2, 4, 6 and 7 return zero. bus_rdata is zero whenever no read is in progress.
- R10: When the read and write strobes are both low under chip select, the access is treated as a write only: no read data is driven and no read-side strobe or pointer move results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when idle |
| stat_in | input | 8 | Channel status byte |
| rx_hold_in | input | 8 | Head of receive FIFO |
| irq_stat_in | input | 8 | Interrupt status byte |
| char_len | output | 2 | Character length code |
| parity_odd | output | 1 | Odd parity select |
| parity_mode | output | 2 | Parity mode |
| block_err_mode | output | 1 | Block error mode |
| rx_irq_on_full | output | 1 | Receive interrupt on FIFO full |
| rx_rts_ctl | output | 1 | Receiver RTS control |
| chan_mode | output | 2 | Channel mode |
| tx_rts_ctl | output | 1 | Transmitter RTS control |
| cts_gates_tx | output | 1 | CTS gates transmitter |
| stop_code | output | 4 | Stop-length code |
| rx_enable | output | 1 | Receiver enabled |
| tx_enable | output | 1 | Transmitter enabled |
| cmd_pulse | output | 12 | One-clock command strobes, bit c-1 for code c |
| clk_sel | output | 8 | Clock select byte |
| tx_hold | output | 8 | Transmit holding byte |
| tx_load | output | 1 | One-clock strobe on transmit-holding write |
| irq_mask | output | 8 | Interrupt mask byte |
| rx_pop | output | 1 | One-clock strobe after a receive-holding read |

## Verification
The bench uses the package defaults: an 8-bit data bus, a 3-bit address and twelve command codes. This lets it sweep the full 4-bit code space, so the four unused codes are exercised beside the twelve live ones. It also lets it reach every one of the eight addresses, including the three that decode to nothing. Random traffic over all addresses, with long and short strobes and data that changes during a strobe, mixes mode-pointer walks with command writes. The behavioural model is checked against the outputs every clock.

// File: rtl/uhr_pkg.sv
package uhr_pkg;
    localparam int DW        = 8;
    localparam int AW        = 3;
    localparam int CODE_W    = 4;
    localparam int NUM_CMDS  = 12;
    localparam int NUM_MODES = 2;
    localparam int PTR_W     = $clog2(NUM_MODES);

    localparam logic [AW-1:0] A_MODE    = AW'(0);
    localparam logic [AW-1:0] A_CLKSTAT = AW'(1);
    localparam logic [AW-1:0] A_CMD     = AW'(2);
    localparam logic [AW-1:0] A_HOLD    = AW'(3);
    localparam logic [AW-1:0] A_IRQ     = AW'(5);

    localparam logic [CODE_W-1:0] CODE_PTR_HOME = CODE_W'(1);

    typedef enum logic [1:0] {LEN5, LEN6, LEN7, LEN8} char_len_e;
    typedef enum logic [1:0] {PAR_WITH, PAR_FORCED, PAR_NONE, PAR_SPECIAL} par_mode_e;
    typedef enum logic [1:0] {CH_NORMAL, CH_ECHO, CH_LLOOP, CH_RLOOP} chan_e;

    typedef struct packed {
        logic      rts_ctl;
        logic      irq_full;
        logic      blk_err;
        par_mode_e pmode;
        logic      odd;
        char_len_e clen;
    } mode1_t;

    typedef struct packed {
        chan_e      chan;
        logic       rts_ctl;
        logic       cts_gate;
        logic [3:0] stop;
    } mode2_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_xfer_t;

    function automatic logic [CODE_W-1:0] cmd_code(input logic [DW-1:0] d);
        return d[DW-1 -: CODE_W];
    endfunction
endpackage

// File: rtl/uhr_bus_port.sv
module uhr_bus_port
    import uhr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rd_active,
    output logic          wr_commit,
    output logic          rd_done,
    output bus_xfer_t     xfer
);
    logic wr_acc, rd_acc, wr_q, rd_q;

    assign wr_acc    = !cs_n && !wr_n;
    assign rd_acc    = !cs_n && !rd_n && wr_n;
    assign rd_active = rd_acc;
    assign wr_commit = wr_q && !wr_acc;
    assign rd_done   = rd_q && !rd_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            xfer <= '0;
        end else begin
            wr_q <= wr_acc;
            rd_q <= rd_acc;
            if (wr_acc || rd_acc)
                xfer <= '{addr: addr, data: wdata};
        end
    end
endmodule

// File: rtl/uhr_mode_bank.sv
module uhr_mode_bank
    import uhr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          adv,
    input  logic          ptr_home,
    output mode1_t        m1,
    output mode2_t        m2,
    output logic [DW-1:0] rd_val
);
    logic [PTR_W-1:0] sel;
    logic [DW-1:0]    regs [NUM_MODES];

    for (genvar i = 0; i < NUM_MODES; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && sel == PTR_W'(i))
                regs[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ptr_home)
            sel <= '0;
        else if ((we || adv) && sel != PTR_W'(NUM_MODES-1))
            sel <= sel + 1'b1;
    end

    assign rd_val = regs[sel];
    assign m1     = mode1_t'(regs[0]);
    assign m2     = mode2_t'(regs[1]);

    p_ptr_home_r3: assert property (@(posedge clk) disable iff (rst)
        ptr_home |=> (sel == '0));
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(m1) && $stable(m2)));
endmodule

// File: rtl/uhr_cmd_unit.sv
module uhr_cmd_unit
    import uhr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [DW-1:0]       wdata,
    output logic                ptr_home,
    output logic                rx_en,
    output logic                tx_en,
    output logic [NUM_CMDS-1:0] pulse
);
    logic [CODE_W-1:0] code;
    assign code     = cmd_code(wdata);
    assign ptr_home = we && (code == CODE_PTR_HOME);

    for (genvar c = 0; c < NUM_CMDS; c++) begin : g_pulse
        always_ff @(posedge clk) begin
            if (rst) pulse[c] <= 1'b0;
            else     pulse[c] <= we && (code == CODE_W'(c + 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
        end else if (we) begin
            if (wdata[1])      rx_en <= 1'b0;
            else if (wdata[0]) rx_en <= 1'b1;
            if (wdata[3])      tx_en <= 1'b0;
            else if (wdata[2]) tx_en <= 1'b1;
        end
    end

    p_pulse_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse));
    p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
        (|pulse) |=> !(|pulse));
    p_rx_dis_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (we && wdata[1]) |=> !rx_en);
    p_tx_dis_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (we && wdata[3]) |=> !tx_en);
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uhr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_cs_n,
    input  logic                bus_rd_n,
    input  logic                bus_wr_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [DW-1:0]       stat_in,
    input  logic [DW-1:0]       rx_hold_in,
    input  logic [DW-1:0]       irq_stat_in,
    output logic [1:0]          char_len,
    output logic                parity_odd,
    output logic [1:0]          parity_mode,
    output logic                block_err_mode,
    output logic                rx_irq_on_full,
    output logic                rx_rts_ctl,
    output logic [1:0]          chan_mode,
    output logic                tx_rts_ctl,
    output logic                cts_gates_tx,
    output logic [3:0]          stop_code,
    output logic                rx_enable,
    output logic                tx_enable,
    output logic [NUM_CMDS-1:0] cmd_pulse,
    output logic [DW-1:0]       clk_sel,
    output logic [DW-1:0]       tx_hold,
    output logic                tx_load,
    output logic [DW-1:0]       irq_mask,
    output logic                rx_pop
);
    logic      rd_active, wr_commit, rd_done, ptr_home;
    bus_xfer_t xfer;
    mode1_t    m1;
    mode2_t    m2;
    logic [DW-1:0] mode_rd;

    uhr_bus_port u_port (
        .clk(clk), .rst(rst), .cs_n(bus_cs_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
        .addr(bus_addr), .wdata(bus_wdata), .rd_active(rd_active),
        .wr_commit(wr_commit), .rd_done(rd_done), .xfer(xfer)
    );

    uhr_cmd_unit u_cmd (
        .clk(clk), .rst(rst), .we(wr_commit && xfer.addr == A_CMD),
        .wdata(xfer.data), .ptr_home(ptr_home), .rx_en(rx_enable),
        .tx_en(tx_enable), .pulse(cmd_pulse)
    );

    uhr_mode_bank u_mode (
        .clk(clk), .rst(rst), .we(wr_commit && xfer.addr == A_MODE),
        .wdata(xfer.data), .adv(rd_done && xfer.addr == A_MODE),
        .ptr_home(ptr_home), .m1(m1), .m2(m2), .rd_val(mode_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sel  <= '0;
            tx_hold  <= '0;
            irq_mask <= '0;
            tx_load  <= 1'b0;
            rx_pop   <= 1'b0;
        end else begin
            tx_load <= wr_commit && xfer.addr == A_HOLD;
            rx_pop  <= rd_done && xfer.addr == A_HOLD;
            if (wr_commit) begin
                case (xfer.addr)
                    A_CLKSTAT: clk_sel  <= xfer.data;
                    A_HOLD:    tx_hold  <= xfer.data;
                    A_IRQ:     irq_mask <= xfer.data;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_active) begin
            case (bus_addr)
                A_MODE:    bus_rdata = mode_rd;
                A_CLKSTAT: bus_rdata = stat_in;
                A_HOLD:    bus_rdata = rx_hold_in;
                A_IRQ:     bus_rdata = irq_stat_in;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign char_len       = m1.clen;
    assign parity_odd     = m1.odd;
    assign parity_mode    = m1.pmode;
    assign block_err_mode = m1.blk_err;
    assign rx_irq_on_full = m1.irq_full;
    assign rx_rts_ctl     = m1.rts_ctl;
    assign chan_mode      = m2.chan;
    assign tx_rts_ctl     = m2.rts_ctl;
    assign cts_gates_tx   = m2.cts_gate;
    assign stop_code      = m2.stop;

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_commit && xfer.addr == A_IRQ) |=> $stable(irq_mask));
    p_load_width_r8: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);
    p_pop_needs_read_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_pop) |-> $past(!bus_wr_n || bus_cs_n || bus_rd_n));
endmodule

// File: tb/sim_uart_host_regs.sv
module sim_uart_host_regs;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata, stat_in = 8'h11, rx_in = 8'h22, irq_in = 8'h33;
    logic [1:0] char_len, parity_mode, chan_mode;
    logic parity_odd, block_err_mode, rx_irq_on_full, rx_rts_ctl, tx_rts_ctl, cts_gates_tx;
    logic [3:0] stop_code;
    logic rx_enable, tx_enable, tx_load, rx_pop;
    logic [11:0] cmd_pulse;
    logic [7:0] clk_sel, tx_hold, irq_mask;

    int tests = 0, fails = 0;
    bit cmp_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_host_regs u0 (
        .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .stat_in(stat_in),
        .rx_hold_in(rx_in), .irq_stat_in(irq_in), .char_len(char_len),
        .parity_odd(parity_odd), .parity_mode(parity_mode),
        .block_err_mode(block_err_mode), .rx_irq_on_full(rx_irq_on_full),
        .rx_rts_ctl(rx_rts_ctl), .chan_mode(chan_mode), .tx_rts_ctl(tx_rts_ctl),
        .cts_gates_tx(cts_gates_tx), .stop_code(stop_code), .rx_enable(rx_enable),
        .tx_enable(tx_enable), .cmd_pulse(cmd_pulse), .clk_sel(clk_sel),
        .tx_hold(tx_hold), .tx_load(tx_load), .irq_mask(irq_mask), .rx_pop(rx_pop)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] mmr [2];
    int mptr;
    bit mw_q, mr_q, mrx, mtx, mload, mpop;
    logic [2:0] ma;
    logic [7:0] md, mclk, mtxh, mmask;
    logic [11:0] mpulse;

    task automatic apply_write(input logic [2:0] a, input logic [7:0] d);
        int code;
        case (a)
            3'd0: begin mmr[mptr] = d; mptr = 1; end
            3'd1: mclk = d;
            3'd2: begin
                code = int'(d[7:4]);
                if (code >= 1 && code <= 12) mpulse[code-1] = 1'b1;
                if (code == 1) mptr = 0;
                if (d[1]) mrx = 0; else if (d[0]) mrx = 1;
                if (d[3]) mtx = 0; else if (d[2]) mtx = 1;
            end
            3'd3: begin mtxh = d; mload = 1; end
            3'd5: mmask = d;
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        bit wa, ra;
        wa = !cs_n && !wr_n;
        ra = !cs_n && !rd_n && wr_n;
        if (rst) begin
            mmr[0] = 0; mmr[1] = 0; mptr = 0; mw_q = 0; mr_q = 0; mrx = 0; mtx = 0;
            mload = 0; mpop = 0; ma = 0; md = 0; mclk = 0; mtxh = 0; mmask = 0; mpulse = 0;
            cmp_on = 1;
        end else begin
            mpulse = 0; mload = 0; mpop = 0;
            if (mw_q && !wa) apply_write(ma, md);
            if (mr_q && !ra) begin
                if (ma == 3'd0) mptr = 1;
                if (ma == 3'd3) mpop = 1;
            end
            mw_q = wa; mr_q = ra;
            if (wa || ra) begin ma = addr; md = wdata; end
        end
    end

    function automatic logic [7:0] exp_rdata();
        if (cs_n || rd_n || !wr_n) return 8'h00;
        case (addr)
            3'd0: return mmr[mptr];
            3'd1: return stat_in;
            3'd3: return rx_in;
            3'd5: return irq_in;
            default: return 8'h00;
        endcase
    endfunction

    always begin
        @(posedge clk);
        #2;
        if (cmp_on) begin
            chk("R8", "rdata", rdata, exp_rdata());
            chk("R4", "char_len", char_len, mmr[0][1:0]);
            chk("R4", "parity_odd", parity_odd, mmr[0][2]);
            chk("R4", "parity_mode", parity_mode, mmr[0][4:3]);
            chk("R4", "block_err", block_err_mode, mmr[0][5]);
            chk("R4", "irq_full", rx_irq_on_full, mmr[0][6]);
            chk("R4", "rx_rts", rx_rts_ctl, mmr[0][7]);
            chk("R5", "chan_mode", chan_mode, mmr[1][7:6]);
            chk("R5", "tx_rts", tx_rts_ctl, mmr[1][5]);
            chk("R5", "cts_gate", cts_gates_tx, mmr[1][4]);
            chk("R5", "stop_code", stop_code, mmr[1][3:0]);
            chk("R7", "rx_enable", rx_enable, mrx);
            chk("R7", "tx_enable", tx_enable, mtx);
            chk("R6", "cmd_pulse", cmd_pulse, mpulse);
            chk("R8", "clk_sel", clk_sel, mclk);
            chk("R8", "tx_hold", tx_hold, mtxh);
            chk("R8", "tx_load", tx_load, mload);
            chk("R8", "irq_mask", irq_mask, mmask);
            chk("R8", "rx_pop", rx_pop, mpop);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input int len = 2);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 0; wr_n = 0;
        repeat (len) @(negedge clk);
        cs_n = 1; wr_n = 1; wdata = ~d;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; cs_n = 0; rd_n = 0;
        @(negedge clk);
        v = rdata;
        @(negedge clk);
        cs_n = 1; rd_n = 1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset enables", {rx_enable, tx_enable}, 0);
        chk("R1", "reset mode fields", {char_len, parity_mode, chan_mode, stop_code}, 0);
        chk("R1", "reset strobes", {cmd_pulse, tx_load, rx_pop}, 0);
        chk("R1", "reset bytes", {clk_sel, tx_hold, irq_mask}, 0);

        // R3 / R4 / R5: pointer walk and field decode
        wr(3'd0, 8'hA5);
        wr(3'd0, 8'h3C);
        wr(3'd0, 8'h3D);
        wr(3'd2, 8'h10);
        rd(3'd0, v); chk("R3", "first read after home", v, 8'hA5);
        rd(3'd0, v); chk("R3", "second read", v, 8'h3D);
        rd(3'd0, v); chk("R3", "pointer stays", v, 8'h3D);
        chk("R4", "char_len A5", char_len, 1);
        chk("R4", "odd A5", parity_odd, 1);
        chk("R4", "block A5", block_err_mode, 1);
        chk("R4", "rts A5", rx_rts_ctl, 1);
        chk("R5", "cts 3D", cts_gates_tx, 1);
        chk("R5", "stop 3D", stop_code, 4'hD);
        wr(3'd2, 8'h10);
        rd(3'd0, v);
        wr(3'd0, 8'hC3);
        chk("R3", "read then write reaches MR2", chan_mode, 3);
        chk("R4", "MR1 untouched", char_len, 1);

        // R6: all sixteen codes
        for (int c = 0; c < 16; c++) wr(3'd2, 8'(c << 4));
        // R7: enable/disable
        wr(3'd2, 8'h05);
        chk("R7", "rx on", rx_enable, 1); chk("R7", "tx on", tx_enable, 1);
        wr(3'd2, 8'h60);
        chk("R7", "hold on code-only write", {rx_enable, tx_enable}, 2'b11);
        wr(3'd2, 8'h0F);
        chk("R7", "disable wins", {rx_enable, tx_enable}, 0);
        wr(3'd2, 8'h74);
        chk("R7", "tx only", {rx_enable, tx_enable}, 2'b01);

        // R8: shared addresses
        wr(3'd1, 8'h77); wr(3'd3, 8'h9E); wr(3'd5, 8'h3B);
        chk("R8", "clk_sel", clk_sel, 8'h77);
        chk("R8", "tx_hold", tx_hold, 8'h9E);
        chk("R8", "irq_mask", irq_mask, 8'h3B);
        stat_in = 8'h4C; rx_in = 8'hD2; irq_in = 8'h81;
        rd(3'd1, v); chk("R8", "status read", v, 8'h4C);
        rd(3'd3, v); chk("R8", "rx hold read", v, 8'hD2);
        rd(3'd5, v); chk("R8", "irq read", v, 8'h81);

        // R9: dead addresses
        wr(3'd4, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        chk("R9", "bytes unchanged", {clk_sel, tx_hold, irq_mask}, 24'h779E3B);
        rd(3'd2, v); chk("R9", "read 2", v, 0);
        rd(3'd4, v); chk("R9", "read 4", v, 0);
        rd(3'd7, v); chk("R9", "read 7", v, 0);

        // R2: no chip select, and data changing within the strobe
        @(negedge clk); addr = 3'd5; wdata = 8'hEE; wr_n = 0;
        repeat (3) @(negedge clk); wr_n = 1;
        repeat (2) @(negedge clk);
        chk("R2", "cs high ignored", irq_mask, 8'h3B);
        @(negedge clk); addr = 3'd5; wdata = 8'h01; cs_n = 0; wr_n = 0;
        @(negedge clk); wdata = 8'h5F;
        @(negedge clk); cs_n = 1; wr_n = 1;
        repeat (2) @(negedge clk);
        chk("R2", "last strobe data", irq_mask, 8'h5F);

        // R10: both strobes low
        @(negedge clk); addr = 3'd3; wdata = 8'h12; cs_n = 0; wr_n = 0; rd_n = 0;
        @(negedge clk); chk("R10", "no read data", rdata, 0);
        @(negedge clk); cs_n = 1; wr_n = 1; rd_n = 1;
        repeat (2) @(negedge clk);
        chk("R10", "write taken", tx_hold, 8'h12);

        // random traffic, compared by the model each clock
        for (int i = 0; i < 400; i++) begin
            logic [2:0] ra;
            ra = 3'($urandom_range(0, 7));
            stat_in = 8'($urandom); rx_in = 8'($urandom); irq_in = 8'($urandom);
            if ($urandom_range(0, 1) == 0) wr(ra, 8'($urandom), $urandom_range(1, 3));
            else rd(ra, v);
        end

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule